// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Each clock cycle it receives the number of times a selected event occurred in that cycle (0 to 7), together with the privilege level the cycle ran at. A configuration register decides how that cycle is counted. The counter can add the raw occurrence count, or it can add one when the count meets a threshold. It can also add one when the count falls below the threshold, or add one only when a qualifying condition first becomes true. Cycles can be restricted to supervisor level, to user levels, or to both.

Software writes the configuration word and the counter value, and reads both back. When the counter wraps past its maximum, a sticky overflow flag is set. The flag drives the interrupt output until software clears it.

Top module: `qual_event_counter`

## Requirements
- R1: After a synchronous active-low reset, `cnt_value`, `cfg_value` and `irq` are all zero.
- R2: Configuration word layout: bits [2:0] threshold, bit 3 edge mode, bit 4 invert, bit 5 supervisor enable, bit 6 user enable, bit 7 global enable. `cfg_value` returns the last word written with `cfg_we`.
- R3: With a zero threshold and edge mode off, each qualified cycle adds `evt_count` (0 to 7) to the counter.
- R4: With a nonzero threshold, invert clear and edge mode off, a qualified cycle adds one when `evt_count` >= threshold, and adds zero otherwise.
- R5: With a nonzero threshold and invert set, a qualified cycle adds one when `evt_count` < threshold. Invert has no effect when the threshold is zero.
- R6: In edge mode, the counter adds one only in a cycle where the condition is true and was false in the previous cycle. The condition is `evt_count` != 0 for a zero threshold, and otherwise the threshold comparison of R4/R5. The remembered previous condition clears on reset and on every configuration write.
- R7: Supervisor enable admits cycles with `priv_level` 0. User enable admits levels 1, 2 and 3. If neither is set, all levels are admitted.
- R8: With the global enable bit clear, the counter does not change except by a software write.
- R9: The counter wraps modulo 2^CNT_W. A wrap sets a sticky overflow flag, and `irq` stays high until `ovf_clr` is pulsed.
- R10: A software write via `cnt_we` loads `cnt_wdata` and takes priority over any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_count | input | 3 | Occurrences of the event in this cycle |
| priv_level | input | 2 | Privilege level of this cycle (0 = supervisor) |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration word to write |
| cnt_we | input | 1 | Write strobe for the counter |
| cnt_wdata | input | CNT_W | Counter value to write |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| cfg_value | output | 8 | Current configuration word |
| cnt_value | output | CNT_W | Current counter value |
| irq | output | 1 | Overflow interrupt (sticky flag) |

## Verification
Every result is due at the first rising edge after the cycle its inputs were presented. This covers the counter increment, the wrap and the setting of `irq`, a software load, a configuration update and the clearing of the flag. The bench drives stimulus on the falling edge and samples one falling edge later, so exactly one rising edge lies between stimulus and check. Edge mode also depends on the condition of the preceding cycle. For this reason, its checks hold a stimulus for several cycles and compare the total added over the whole stretch. The threshold, invert and privilege rules are swept exhaustively, one counted cycle per check, starting from a freshly written counter.

// File: rtl/qec_pkg.sv
// Package: shared widths and configuration word layout for the
// qualified event counter. Assumes the per-cycle event count and the
// threshold share one width.
package qec_pkg;
    localparam int EVT_W  = 3;
    localparam int PRIV_W = 2;
    localparam int CFG_W  = EVT_W + 5;

    typedef struct packed {
        logic             glb_en;
        logic             usr_en;
        logic             sup_en;
        logic             inv;
        logic             edge_en;
        logic [EVT_W-1:0] thr;
    } qec_cfg_t;
endpackage

// File: rtl/qec_qualifier.sv
// Module: qec_qualifier
// Purely combinational. Decides, for one cycle, whether the cycle is
// admitted by the privilege and global enables. It forms the qualified
// condition used by edge mode, and the amount to add when edge mode is off.
// Assumes cfg is a registered configuration word.
module qec_qualifier
    import qec_pkg::*;
(
    input  qec_cfg_t          cfg,
    input  logic [EVT_W-1:0]  evt,
    input  logic [PRIV_W-1:0] priv,
    output logic              cond,
    output logic [EVT_W-1:0]  amt
);
    logic admit;
    logic cmp;

    // Privilege admission: no enable set means both are admitted.
    always_comb begin
        if (!cfg.sup_en && !cfg.usr_en) admit = cfg.glb_en;
        else if (priv == '0)            admit = cfg.glb_en && cfg.sup_en;
        else                            admit = cfg.glb_en && cfg.usr_en;
    end

    // Threshold comparison; invert only matters with a nonzero threshold.
    always_comb begin
        if (cfg.thr == '0)   cmp = (evt != '0);
        else if (cfg.inv)    cmp = (evt < cfg.thr);
        else                 cmp = (evt >= cfg.thr);
    end

    // Qualified condition and non-edge increment amount.
    always_comb begin
        cond = admit && cmp;
        if (!admit)              amt = '0;
        else if (cfg.thr == '0)  amt = evt;
        else                     amt = {{(EVT_W-1){1'b0}}, cmp};
    end
endmodule

// File: rtl/qec_edge.sv
// Module: qec_edge
// Rising-edge detector on the qualified condition. The previous-cycle
// condition is held in a register that clears on reset and on every
// configuration write. Assumes cond is valid every cycle.
module qec_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cond,
    output logic pulse
);
    logic prev_q;

    // Remember last cycle's condition; forget it on reset or config write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) prev_q <= 1'b0;
        else               prev_q <= cond;
    end

    // One-cycle pulse on a false-to-true transition.
    always_comb pulse = cond && !prev_q;

    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !clr) |=> !pulse);
endmodule

// File: rtl/qec_accum.sv
// Module: qec_accum
// Counter register with software load and sticky overflow flag. A load
// has priority over the increment. The flag is set on a carry out of
// the top bit and held until cleared; a set in the same cycle wins over
// a clear. Assumes CNT_W > INC_W.
module qec_accum #(
    parameter int CNT_W = 48,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam int PAD_W = CNT_W - INC_W;

    logic [CNT_W:0] sum;

    // Widened sum whose top bit is the wrap carry.
    always_comb sum = {1'b0, cnt} + {1'b0, {PAD_W{1'b0}}, inc};

    // Counter: load first, otherwise accumulate modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else           cnt <= sum[CNT_W-1:0];
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf <= 1'b0;
        else if (!load && sum[CNT_W]) ovf <= 1'b1;
        else if (ovf_clr)           ovf <= 1'b0;
    end

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    assert_wrap_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((cnt >= $past(cnt)) || ovf));
endmodule

// File: rtl/qual_event_counter.sv
// Module: qual_event_counter (top)
// One programmable event counter. It qualifies each cycle by privilege
// and global enable, applies threshold, invert and edge rules, and
// accumulates into a CNT_W-bit counter with an overflow interrupt.
// Assumes one event count per clock and a synchronous active-low reset.
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_count,
    input  logic [PRIV_W-1:0] priv_level,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ovf_clr,
    output logic [CFG_W-1:0]  cfg_value,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              irq
);
    qec_cfg_t         cfg_q;
    logic             cond;
    logic             pulse;
    logic [EVT_W-1:0] amt;
    logic [EVT_W-1:0] inc;

    // Configuration register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= qec_cfg_t'(cfg_wdata);
    end

    qec_qualifier u_qual (
        .cfg  (cfg_q),
        .evt  (evt_count),
        .priv (priv_level),
        .cond (cond),
        .amt  (amt)
    );

    qec_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_we),
        .cond  (cond),
        .pulse (pulse)
    );

    // Pick edge pulse or level amount as this cycle's increment.
    always_comb inc = cfg_q.edge_en ? {{(EVT_W-1){1'b0}}, pulse} : amt;

    qec_accum #(.CNT_W(CNT_W), .INC_W(EVT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .load     (cnt_we),
        .load_val (cnt_wdata),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt_value),
        .ovf      (irq)
    );

    always_comb cfg_value = cfg_q;

    assert_glb_off_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.glb_en && !cnt_we) |=> $stable(cnt_value));
    assert_edge_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.edge_en && !cnt_we) |=> (CNT_W'(cnt_value - $past(cnt_value)) <= CNT_W'(1)));
    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_value == $past(cfg_wdata)));
endmodule

// File: tb/qual_event_counter_bench.sv
module qual_event_counter_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    evt_count = '0;
    logic [1:0]    priv_level = '0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          ovf_clr = 1'b0;
    logic [7:0]    cfg_value;
    logic [CW-1:0] cnt_value;
    logic          irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    qual_event_counter #(.CNT_W(CW)) u_qual_event_counter (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .priv_level(priv_level),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ovf_clr(ovf_clr), .cfg_value(cfg_value), .cnt_value(cnt_value), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [7:0] mk(input int thr, input bit ed, input bit inv,
                                      input bit sup, input bit usr, input bit glb);
        return {glb, usr, sup, inv, ed, 3'(thr)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write config and clear counter in one cycle, then idle inputs.
    task automatic setup(input logic [7:0] c, input int start);
        cfg_we = 1'b1; cfg_wdata = c; cnt_we = 1'b1; cnt_wdata = CW'(start);
        evt_count = '0;
        @(negedge clk);
        cfg_we = 1'b0; cnt_we = 1'b0;
    endtask

    task automatic run(input int e, input int n);
        evt_count = 3'(e);
        repeat (n) @(negedge clk);
        evt_count = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cnt", int'(cnt_value), 0);
        chk("R1 cfg", int'(cfg_value), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 config readback
        setup(mk(5, 1, 0, 1, 0, 1), 0);
        chk("R2 cfg readback", int'(cfg_value), 8'hAD);

        // R3 R4 R5 exhaustive sweep of threshold, invert and event count
        for (int t = 0; t < 8; t++)
            for (int iv = 0; iv < 2; iv++)
                for (int e = 0; e < 8; e++) begin
                    int exp;
                    setup(mk(t, 0, iv[0], 0, 0, 1), 0);
                    run(e, 1);
                    if (t == 0)       exp = e;
                    else if (iv == 1) exp = (e < t) ? 1 : 0;
                    else              exp = (e >= t) ? 1 : 0;
                    chk(t == 0 ? "R3 raw add" : (iv == 1 ? "R5 inverted" : "R4 threshold"),
                        int'(cnt_value), exp);
                end

        // R7 privilege qualification sweep
        for (int s = 0; s < 2; s++)
            for (int u = 0; u < 2; u++)
                for (int p = 0; p < 4; p++) begin
                    int exp;
                    setup(mk(0, 0, 0, s[0], u[0], 1), 0);
                    priv_level = 2'(p);
                    run(1, 1);
                    if (s == 0 && u == 0) exp = 1;
                    else                  exp = (p == 0) ? s : u;
                    chk("R7 privilege", int'(cnt_value), exp);
                end
        priv_level = '0;

        // R6 edge mode: held condition counts once, re-arm counts again
        setup(mk(2, 1, 0, 0, 0, 1), 0);
        run(5, 4);
        chk("R6 held once", int'(cnt_value), 1);
        run(0, 1);
        run(3, 2);
        chk("R6 second rise", int'(cnt_value), 2);
        run(1, 2);
        chk("R6 below thr no rise", int'(cnt_value), 2);
        // R6 zero threshold edge: condition is evt != 0
        setup(mk(0, 1, 0, 0, 0, 1), 0);
        run(7, 3);
        chk("R6 zero thr edge", int'(cnt_value), 1);
        // R6 config write clears remembered condition while condition held
        evt_count = 3'd7;
        cfg_we = 1'b1; cfg_wdata = mk(0, 1, 0, 0, 0, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R6 cfg write rearms", int'(cnt_value), 2);
        evt_count = '0;

        // R8 global enable off
        setup(mk(0, 0, 0, 0, 0, 0), 9);
        run(7, 4);
        chk("R8 global off", int'(cnt_value), 9);

        // R9 wrap and sticky interrupt
        setup(mk(0, 0, 0, 0, 0, 1), 254);
        chk("R9 irq before wrap", int'(irq), 0);
        run(3, 1);
        chk("R9 wrapped value", int'(cnt_value), 1);
        chk("R9 irq set", int'(irq), 1);
        run(0, 3);
        chk("R9 irq sticky", int'(irq), 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 irq cleared", int'(irq), 0);

        // R10 software write beats increment
        evt_count = 3'd7; cnt_we = 1'b1; cnt_wdata = 8'h40;
        @(negedge clk);
        cnt_we = 1'b0; evt_count = '0;
        chk("R10 write priority", int'(cnt_value), 64);
        run(2, 1);
        chk("R10 counts after write", int'(cnt_value), 66);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule